// File: doc/BRIEF.md
# Serial Flash Maintenance Sequencer

This block runs the bus-level steps of serial-flash maintenance so that no software has to drive them. A single start pulse brings in one request: a whole-chip erase, a sector erase of a chosen size, a page program, or an identification read. The request carries a bank number, a 24-bit byte address, a program length and, for page program, a byte stream. The sequencer turns the request into a series of SPI transfers. It sends a write-enable transaction, then the command word with its address, then any payload bytes. It then polls the status register, holding the device selected throughout the poll, until the device reports that it has finished.

Inside the block, a bit-serial engine drives SPI mode 0: the clock idles low and data is sampled on the rising edge. The engine transfers a word of 0 to 32 bits, most significant bit first. After each transfer it either keeps chip select asserted or releases it. A fan-out stage maps the bank number onto one of three active-low chip selects. Payload bytes are pulled from the requester one at a time through a take strobe. At the end of every request the block gives a one-cycle done pulse. An error flag rides on the same cycle when the request was refused.

Top module: `flash_op_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, all chip selects are high, sclk is low, and busy, done and err are 0.
- R2: Erase and program requests begin with a separate, terminated 8-bit transaction carrying opcode 0x06. An identification read sends no write enable.
- R3: A chip erase (op code 0) sends opcode 0xC7 as one terminated 8-bit transaction, placed after the write enable.
- R4: A sector erase (op code 1) sends one terminated 32-bit transaction. Its first byte is the size opcode: 0x20 for 4 KiB, 0x52 for 32 KiB and 0xD8 for 64 KiB, with the size given in KiB on sect_kib. The first byte is followed by address bits 23:16, 15:8 and 7:0.
- R5: Any other sector size ends the request with done and err both high in the same cycle, and no chip select ever goes low.
- R6: A page program (op code 2) sends 0x02 and the three address bytes, then the payload bytes in the order they were taken, all in one transaction that ends after the last byte. data_take pulses exactly once for each payload byte, and data_byte is sampled in that same cycle.
- R7: A page program with a length of 0 or more than 256 is refused in the same way as R5. A length of exactly 256 is accepted.
- R8: After each erase or program transfer, a single transaction sends 0x05 and then reads dummy bytes until a status byte with bit 0 clear arrives. The sequencer then releases chip select and raises done.
- R9: An identification read (op code 3) sends 0x9F followed by 24 clock bits in one terminated transaction. id_out then holds the three bytes received, with the first byte in bits 23:16.
- R10: Bank values 0, 1 and 2 drive cs_n[0], cs_n[1] and cs_n[2] respectively, and bank 3 falls back to cs_n[0]. At most one chip select is ever low.
- R11: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse with busy low. A start that arrives while busy is ignored.
- R12: SPI mode 0 is used: mosi does not change while sclk is high, and sclk stays low whenever no chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe; it is accepted only when the block is idle |
| op | input | 2 | Request type: 0 chip erase, 1 sector erase, 2 page program, 3 identification read |
| bank | input | 2 | Device bank select |
| sect_kib | input | 7 | Sector size in KiB, used for sector erase |
| addr | input | 24 | Byte address on the device |
| len | input | 9 | Page-program byte count |
| data_byte | input | 8 | Payload byte; must be valid in the cycle data_take is high |
| data_take | output | 1 | Pulses once for each payload byte consumed |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request ends |
| err | output | 1 | High together with done when the request was refused |
| id_out | output | 24 | Result of the last identification read |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | 3 | Active-low chip selects |

## Verification
The hardest state to reach from the ports is the status poll. It only runs while the device reports that it is busy, and it has to keep one chip select low across a number of 8-bit reads that cannot be known in advance. The bench uses a behavioural device model that decodes each transaction. Before every request it is loaded with the number of busy status bytes it should return, from none up to several. The bench then checks that exactly that many dummy reads plus one were made, and that all of them happened inside a single chip-select window. The boundary lengths of page program (0, 256 and 257) and a start pulse placed in the middle of a running erase are each driven by their own task.

// File: rtl/flash_seq_pkg.sv
// Package: opcodes, request codes and sequencer states shared by the
// serial-flash sequencer modules. Assumes a 24-bit device address.
package flash_seq_pkg;
    localparam int ADDR_W   = 24;
    localparam int WORD_W   = 32;
    localparam int BITS_W   = 6;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_CHIP   = 8'hC7;
    localparam logic [7:0] OPC_SEC4   = 8'h20;
    localparam logic [7:0] OPC_SEC32  = 8'h52;
    localparam logic [7:0] OPC_SEC64  = 8'hD8;
    localparam logic [7:0] OPC_IDENT  = 8'h9F;

    typedef enum logic [1:0] {
        REQ_CHIP  = 2'd0,
        REQ_SECT  = 2'd1,
        REQ_PROG  = 2'd2,
        REQ_IDENT = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WREN, ST_CMD, ST_DATA, ST_RDSR, ST_POLL, ST_PEND, ST_FIN
    } seq_state_e;
endpackage

// File: rtl/spi_bit_engine.sv
// spi_bit_engine: shifts out 0..32 bits of a word, MSB first, in SPI mode 0.
// Each bit takes two clocks (sclk low, then sclk high). miso is captured at
// the end of the high phase. Chip select stays asserted after a transfer
// unless term is set. A zero-bit transfer only applies term.
// Assumes go is raised only when no transfer is running.
module spi_bit_engine
    import flash_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [WORD_W-1:0]   word,
    input  logic [BITS_W-1:0]   bits,
    input  logic                term,
    output logic                xfer_done,
    output logic [WORD_W-1:0]   rx,
    output logic                cs_low,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso
);
    logic                active;
    logic                phase;
    logic                term_q;
    logic [BITS_W-1:0]   cnt;
    logic [WORD_W-1:0]   sh;

    // Bit-level transfer control, shift and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            phase     <= 1'b0;
            term_q    <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
            rx        <= '0;
            cs_low    <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    term_q <= term;
                    if (bits == '0) begin
                        if (term) cs_low <= 1'b0;
                        xfer_done <= 1'b1;
                    end else begin
                        cs_low <= 1'b1;
                        active <= 1'b1;
                        phase  <= 1'b0;
                        cnt    <= bits;
                        sh     <= word << (7'd32 - {1'b0, bits});
                        rx     <= '0;
                    end
                end
            end else if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                rx    <= {rx[WORD_W-2:0], miso};
                sh    <= {sh[WORD_W-2:0], 1'b0};
                cnt   <= cnt - 1'b1;
                if (cnt == BITS_W'(1)) begin
                    active    <= 1'b0;
                    xfer_done <= 1'b1;
                    if (term_q) cs_low <= 1'b0;
                end
            end
        end
    end

    // Serial pins follow the phase and the shift register head.
    always_comb begin
        sclk = active & phase;
        mosi = sh[WORD_W-1];
    end
endmodule

// File: rtl/cs_fanout.sv
// cs_fanout: maps a bank number onto one of NCS active-low chip selects.
// Bank values at or above NCS fall back to select 0.
module cs_fanout #(
    parameter int NCS    = 3,
    parameter int BANK_W = 2
) (
    input  logic              cs_low,
    input  logic [BANK_W-1:0] bank,
    output logic [NCS-1:0]    cs_n
);
    logic [BANK_W-1:0] sel;

    // Fold out-of-range banks onto select 0.
    always_comb begin
        sel = (int'(bank) < NCS) ? bank : '0;
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(cs_low && (int'(sel) == g));
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
// flash_cmd_fsm: runs one flash maintenance request as a list of engine
// transfers: write enable, command word, payload, then a status poll.
// Checks the sector size and program length before any bus activity.
// Assumes request fields are valid in the cycle start is high.
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter int MAX_PAGE = 256,
    parameter int LEN_W    = $clog2(MAX_PAGE) + 1,
    parameter int BANK_W   = 2,
    parameter int KIB_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [BANK_W-1:0]   bank,
    input  logic [KIB_W-1:0]    sect_kib,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LEN_W-1:0]    len,
    input  logic [7:0]          data_byte,
    output logic                data_take,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [ADDR_W-1:0]   id_out,
    output logic [BANK_W-1:0]   bank_q,
    output logic                go,
    output logic [WORD_W-1:0]   word,
    output logic [BITS_W-1:0]   bits,
    output logic                term,
    input  logic                xfer_done,
    input  logic [WORD_W-1:0]   rx
);
    seq_state_e          st;
    req_e                req_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          sec_opc_q;
    logic [LEN_W-1:0]    left;
    logic                waiting;
    logic                bad_q;
    logic                sec_ok;
    logic [7:0]          sec_opc;
    logic                len_ok;

    // Size-to-opcode lookup and length check for the incoming request.
    always_comb begin
        sec_ok  = 1'b1;
        sec_opc = OPC_SEC4;
        case (sect_kib)
            KIB_W'(4):  sec_opc = OPC_SEC4;
            KIB_W'(32): sec_opc = OPC_SEC32;
            KIB_W'(64): sec_opc = OPC_SEC64;
            default:    sec_ok  = 1'b0;
        endcase
        len_ok = (len != '0) && (int'(len) <= MAX_PAGE);
    end

    // Transfer descriptor for the current state.
    always_comb begin
        word = '0;
        bits = BITS_W'(8);
        term = 1'b1;
        case (st)
            ST_WREN: word = {24'h0, OPC_WREN};
            ST_CMD: begin
                case (req_q)
                    REQ_CHIP:  word = {24'h0, OPC_CHIP};
                    REQ_SECT:  begin word = {sec_opc_q, addr_q}; bits = BITS_W'(32); end
                    REQ_PROG:  begin word = {OPC_PROG, addr_q}; bits = BITS_W'(32); term = 1'b0; end
                    default:   begin word = {OPC_IDENT, 24'h0}; bits = BITS_W'(32); end
                endcase
            end
            ST_DATA: begin word = {24'h0, data_byte}; term = (left == LEN_W'(1)); end
            ST_RDSR: begin word = {24'h0, OPC_RDSR}; term = 1'b0; end
            ST_POLL: term = 1'b0;
            ST_PEND: bits = '0;
            default: ;
        endcase
        go        = !waiting && (st inside {ST_WREN, ST_CMD, ST_DATA, ST_RDSR, ST_POLL, ST_PEND});
        data_take = go && (st == ST_DATA);
        busy      = (st != ST_IDLE);
    end

    // Request sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            req_q     <= REQ_CHIP;
            addr_q    <= '0;
            sec_opc_q <= '0;
            left      <= '0;
            waiting   <= 1'b0;
            bad_q     <= 1'b0;
            bank_q    <= '0;
            id_out    <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (go) waiting <= 1'b1;
            case (st)
                ST_IDLE: if (start) begin
                    req_q     <= req_e'(op);
                    addr_q    <= addr;
                    sec_opc_q <= sec_opc;
                    left      <= len;
                    bank_q    <= bank;
                    bad_q     <= 1'b0;
                    if ((req_e'(op) == REQ_SECT && !sec_ok) ||
                        (req_e'(op) == REQ_PROG && !len_ok)) begin
                        bad_q <= 1'b1;
                        st    <= ST_FIN;
                    end else if (req_e'(op) == REQ_IDENT) begin
                        st <= ST_CMD;
                    end else begin
                        st <= ST_WREN;
                    end
                end
                ST_FIN: begin
                    done <= 1'b1;
                    err  <= bad_q;
                    st   <= ST_IDLE;
                end
                default: if (waiting && xfer_done) begin
                    waiting <= 1'b0;
                    case (st)
                        ST_WREN: st <= ST_CMD;
                        ST_CMD: begin
                            if (req_q == REQ_IDENT) begin
                                id_out <= rx[ADDR_W-1:0];
                                st     <= ST_FIN;
                            end else if (req_q == REQ_PROG) begin
                                st <= ST_DATA;
                            end else begin
                                st <= ST_RDSR;
                            end
                        end
                        ST_DATA: begin
                            left <= left - 1'b1;
                            if (left == LEN_W'(1)) st <= ST_RDSR;
                        end
                        ST_RDSR: st <= ST_POLL;
                        ST_POLL: if (!rx[0]) st <= ST_PEND;
                        default: st <= ST_FIN;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_op_seq.sv
// flash_op_seq: top of the serial-flash maintenance sequencer. It joins the
// request FSM, the bit engine and the chip-select fan-out.
// Assumes one SPI mode 0 device on each chip select.
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int NCS      = 3,
    parameter int BANK_W   = 2,
    parameter int KIB_W    = 7,
    parameter int MAX_PAGE = 256,
    parameter int LEN_W    = $clog2(MAX_PAGE) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op,
    input  logic [BANK_W-1:0]  bank,
    input  logic [KIB_W-1:0]   sect_kib,
    input  logic [23:0]        addr,
    input  logic [LEN_W-1:0]   len,
    input  logic [7:0]         data_byte,
    output logic               data_take,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [23:0]        id_out,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NCS-1:0]     cs_n
);
    logic                go;
    logic [WORD_W-1:0]   word;
    logic [BITS_W-1:0]   bits;
    logic                term;
    logic                xfer_done;
    logic [WORD_W-1:0]   rx;
    logic                cs_low;
    logic [BANK_W-1:0]   bank_q;

    flash_cmd_fsm #(.MAX_PAGE(MAX_PAGE), .LEN_W(LEN_W), .BANK_W(BANK_W), .KIB_W(KIB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank),
        .sect_kib(sect_kib), .addr(addr), .len(len), .data_byte(data_byte),
        .data_take(data_take), .busy(busy), .done(done), .err(err),
        .id_out(id_out), .bank_q(bank_q), .go(go), .word(word), .bits(bits),
        .term(term), .xfer_done(xfer_done), .rx(rx)
    );

    spi_bit_engine u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .word(word), .bits(bits),
        .term(term), .xfer_done(xfer_done), .rx(rx), .cs_low(cs_low),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    cs_fanout #(.NCS(NCS), .BANK_W(BANK_W)) u_cs (
        .cs_low(cs_low), .bank(bank_q), .cs_n(cs_n)
    );
endmodule

// File: rtl/flash_op_seq_chk.sv
// flash_op_seq_chk: protocol properties of the sequencer ports, bound to
// every instance of flash_op_seq.
module flash_op_seq_chk #(
    parameter int NCS = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           err,
    input logic           data_take,
    input logic           sclk,
    input logic           mosi,
    input logic [NCS-1:0] cs_n
);
    a_r10_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    a_r12_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
    a_r12_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    a_r8_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n));
    a_r6_take_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |-> busy);
endmodule

bind flash_op_seq flash_op_seq_chk #(.NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .data_take(data_take), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/tb_flash_op_seq.sv
// Directed bench for flash_op_seq with a behavioural mode-0 flash model.
module tb_flash_op_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  bank = '0;
    logic [6:0]  sect_kib = '0;
    logic [23:0] addr = '0;
    logic [8:0]  len = '0;
    logic [7:0]  data_byte;
    logic        data_take, busy, done, err, sclk, mosi;
    logic        miso = 1'b0;
    logic [23:0] id_out;
    logic [2:0]  cs_n;

    int nchk = 0, nfail = 0;
    int didx = 0;
    int busy_left = 0;
    localparam logic [23:0] DEV_ID = 24'hC2_20_17;

    // Transaction log kept by the device model.
    int          nlog = 0;
    int          cur = 0;
    int          llen [0:7];
    int          lcs  [0:7];
    logic [7:0]  lb   [0:7][0:299];
    logic [7:0]  sr = '0, out_sr = '0;
    int          bitc = 0;
    logic        prev_idle = 1'b1;

    flash_op_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank),
        .sect_kib(sect_kib), .addr(addr), .len(len), .data_byte(data_byte),
        .data_take(data_take), .busy(busy), .done(done), .err(err),
        .id_out(id_out), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    assign data_byte = 8'((didx * 7 + 3) & 255);
    always @(posedge clk) if (data_take) didx <= didx + 1;

    // Device model: opens a log entry when a chip select falls.
    always @(cs_n) begin
        if (!(&cs_n) && prev_idle === 1'b1) begin
            cur = nlog;
            if (nlog < 8) nlog = nlog + 1;
            llen[cur] = 0;
            lcs[cur] = (cs_n == 3'b110) ? 0 : (cs_n == 3'b101) ? 1 : (cs_n == 3'b011) ? 2 : 9;
            bitc = 0;
        end
        prev_idle = &cs_n;
    end

    always @(posedge sclk) if (!(&cs_n)) begin
        sr = {sr[6:0], mosi};
        bitc = bitc + 1;
        if (bitc == 8) begin
            bitc = 0;
            if (cur < 8 && llen[cur] < 300) lb[cur][llen[cur]] = sr;
            llen[cur] = llen[cur] + 1;
            out_sr = 8'h00;
            if (lb[cur][0] == 8'h05) begin
                out_sr = (busy_left > 0) ? 8'h01 : 8'h00;
                if (busy_left > 0) busy_left = busy_left - 1;
            end else if (lb[cur][0] == 8'h9F) begin
                if (llen[cur] == 1) out_sr = DEV_ID[23:16];
                else if (llen[cur] == 2) out_sr = DEV_ID[15:8];
                else if (llen[cur] == 3) out_sr = DEV_ID[7:0];
            end
        end
    end

    always @(negedge sclk) begin
        miso = out_sr[7];
        out_sr = {out_sr[6:0], 1'b0};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one request and wait for its done pulse.
    task automatic run_op(input int o, input int b, input int kib, input int a,
                          input int n, input int polls, output bit got_err);
        int cyc;
        bit seen;
        nlog = 0; didx = 0; busy_left = polls; seen = 0; got_err = 0;
        @(negedge clk);
        op = 2'(o); bank = 2'(b); sect_kib = 7'(kib); addr = 24'(a); len = 9'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (cyc = 0; cyc < 20000; cyc++) begin
            if (done) begin seen = 1; got_err = err; break; end
            @(negedge clk);
        end
        chk(seen, "R11", "done seen", seen, 1);
        @(negedge clk);
        chk(!done, "R11", "done single cycle", done, 0);
        chk(&cs_n && !sclk, "R12", "bus idle after op", {cs_n, sclk}, 4'b1110);
    endtask

    task automatic t_reset;
        chk(cs_n == 3'b111, "R1", "cs_n at reset", cs_n, 3'b111);
        chk(!sclk && !busy && !done && !err, "R1", "sclk/busy/done/err", {sclk, busy, done, err}, 0);
    endtask

    task automatic t_chip_erase;
        bit e;
        run_op(0, 0, 0, 0, 0, 3, e);
        chk(!e, "R3", "err", e, 0);
        chk(nlog == 3, "R3", "transactions", nlog, 3);
        chk(llen[0] == 1 && lb[0][0] == 8'h06, "R2", "wren", lb[0][0], 8'h06);
        chk(llen[1] == 1 && lb[1][0] == 8'hC7, "R3", "erase opcode", lb[1][0], 8'hC7);
        chk(lb[2][0] == 8'h05, "R8", "poll opcode", lb[2][0], 8'h05);
        chk(llen[2] == 5, "R8", "poll length", llen[2], 5);
        chk(lcs[0] == 0 && lcs[1] == 0 && lcs[2] == 0, "R10", "bank0 cs", lcs[2], 0);
    endtask

    task automatic t_sector(input int kib, input logic [7:0] opc);
        bit e;
        run_op(1, 1, kib, 24'hA5_3C_81, 0, 0, e);
        chk(!e && nlog == 3, "R4", "err/transactions", nlog, 3);
        chk(lb[0][0] == 8'h06 && llen[0] == 1, "R2", "wren", lb[0][0], 8'h06);
        chk(llen[1] == 4 && lb[1][0] == opc, "R4", "size opcode", lb[1][0], opc);
        chk({lb[1][1], lb[1][2], lb[1][3]} == 24'hA53C81, "R4", "address",
            {lb[1][1], lb[1][2], lb[1][3]}, 24'hA53C81);
        chk(llen[2] == 2, "R8", "poll length no busy", llen[2], 2);
        chk(lcs[1] == 1, "R10", "bank1 cs", lcs[1], 1);
    endtask

    task automatic t_bad_sector(input int kib);
        bit e;
        run_op(1, 0, kib, 0, 0, 0, e);
        chk(e, "R5", "err on bad size", e, 1);
        chk(nlog == 0, "R5", "no bus activity", nlog, 0);
    endtask

    task automatic t_prog(input int n, input int polls);
        bit e;
        bit ok;
        run_op(2, 2, 0, 24'h01_02_F0, n, polls, e);
        chk(!e && nlog == 3, "R6", "err/transactions", nlog, 3);
        chk(lb[0][0] == 8'h06, "R2", "wren", lb[0][0], 8'h06);
        chk(llen[1] == n + 4, "R6", "one cs window", llen[1], n + 4);
        chk({lb[1][0], lb[1][1], lb[1][2], lb[1][3]} == 32'h020102F0, "R6", "cmd word",
            {lb[1][0], lb[1][1], lb[1][2], lb[1][3]}, 32'h020102F0);
        ok = 1;
        for (int i = 0; i < n; i++) if (lb[1][4 + i] != 8'((i * 7 + 3) & 255)) ok = 0;
        chk(ok, "R6", "payload order", ok, 1);
        chk(didx == n, "R6", "take count", didx, n);
        chk(llen[2] == polls + 2, "R8", "poll length", llen[2], polls + 2);
        chk(lcs[1] == 2, "R10", "bank2 cs", lcs[1], 2);
    endtask

    task automatic t_prog_reject(input int n);
        bit e;
        run_op(2, 0, 0, 0, n, 0, e);
        chk(e, "R7", "err on length", e, 1);
        chk(nlog == 0 && didx == 0, "R7", "no bus/no take", nlog, 0);
    endtask

    task automatic t_ident;
        bit e;
        run_op(3, 3, 0, 0, 0, 0, e);
        chk(!e && nlog == 1, "R9", "single transaction, no wren (R2)", nlog, 1);
        chk(llen[0] == 4 && lb[0][0] == 8'h9F, "R9", "opcode", lb[0][0], 8'h9F);
        chk(id_out == DEV_ID, "R9", "id", id_out, DEV_ID);
        chk(lcs[0] == 0, "R10", "bank3 falls back to cs0", lcs[0], 0);
    endtask

    task automatic t_start_while_busy;
        int cyc;
        bit seen;
        nlog = 0; didx = 0; busy_left = 2; seen = 0;
        @(negedge clk);
        op = 2'd0; bank = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11", "busy after start", busy, 1);
        repeat (30) @(negedge clk);
        op = 2'd3; bank = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (cyc = 0; cyc < 20000; cyc++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen && !busy, "R11", "done with busy low", busy, 0);
        repeat (80) @(negedge clk);
        chk(nlog == 3, "R11", "second start ignored", nlog, 3);
        chk(lcs[0] == 1 && lcs[2] == 1 && lb[1][0] == 8'hC7, "R11", "first request kept", lb[1][0], 8'hC7);
    endtask

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_chip_erase;
        t_sector(4, 8'h20);
        t_sector(32, 8'h52);
        t_sector(64, 8'hD8);
        t_bad_sector(16);
        t_bad_sector(0);
        t_prog(5, 1);
        t_prog_reject(0);
        t_prog_reject(257);
        t_prog(256, 0);
        t_ident;
        t_start_while_busy;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule